// File: doc/BRIEF.md
# Timed Command Playback and Event Recorder

This block drives an event-based neural emulation device from a list of commands prepared in advance. The host link is too slow to feed the device live, so the block first takes in the whole command list. It then plays the list back on its own. While the list plays, it records what the device emits. When the run is over, the host drains the record.

Each stored command does one of four things:
- it writes a configuration word to the device;
- it schedules an input spike that is held back until a free-running timestamp reaches its due time;
- it marks the start of the emulation and restarts the timestamp from zero;
- it closes the list.

While the run is active, every output spike from the device is stored in a small record buffer together with the current timestamp. A sticky flag shows whether any event was lost because the buffer was full.

The block moves through three phases in a fixed order: loading, running, draining. A pulse on `run_go` moves it from loading to running. The same pulse given while draining clears everything and returns the block to loading for the next experiment.

Top module: `spike_playback_top`

## Requirements
- R1: In the loading phase `cmd_ready` is high while fewer than CMD_DEPTH words are stored. A word is stored when `cmd_valid` and `cmd_ready` are both high. When the list is full, `cmd_ready` is low and further words are dropped. A `run_go` pulse while loading starts the run.
- R2: A command with bits [31:30] = 00 is a configuration write. In the cycle after the block executes it, `cfg_valid` pulses for one cycle, with `cfg_addr` taken from bits [29:16] and `cfg_data` from bits [15:0].
- R3: A command with bits [31:30] = 01 is an input spike. Its neuron index is in bits [23:16] and its due time in bits [15:0]. It waits until the timestamp counter is equal to or greater than the due time. In the cycle after release, `stim_valid` pulses with `stim_idx`. Later commands wait behind it.
- R4: A command with bits [31:30] = 10 pulses `emu_start` for one cycle and restarts the timestamp counter at zero. The counter is also zero in the first cycle of the run and rises by one every run cycle after that.
- R5: The run ends on any of three conditions: a command with bits [31:30] = 11, all stored commands used up, or `run_timeout` elapsed cycles since the run began when `run_timeout` is nonzero. `busy` is high exactly during the run.
- R6: In each run cycle with `dev_spk_valid` high, one 24-bit record is appended to the buffer. The record holds the device neuron index in bits [23:16] and the current timestamp in bits [15:0].
- R7: If `dev_spk_valid` arrives during a run while the buffer already holds REC_DEPTH records, the event is dropped. `overflow` is then set and stays set until the block is cleared.
- R8: In the draining phase `rd_valid` is high while records remain. `rd_data` shows the oldest record and is removed when `rd_ready` is high. `rd_done` is high when the buffer is empty.
- R9: A `run_go` pulse while draining returns the block to loading. It empties the command list and the record buffer and clears `overflow`.
- R10: After reset the block is loading, with an empty list and an empty buffer, `overflow` low and all pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered while loading |
| cmd_data | input | 32 | Command word |
| cmd_ready | output | 1 | Command word can be accepted |
| run_go | input | 1 | Starts a run, or leaves the draining phase |
| run_timeout | input | TO_W | Run cycle limit, 0 disables it |
| busy | output | 1 | Run in progress |
| cfg_valid | output | 1 | Configuration write pulse |
| cfg_addr | output | 14 | Configuration address |
| cfg_data | output | 16 | Configuration data |
| stim_valid | output | 1 | Input spike pulse to the device |
| stim_idx | output | 8 | Input spike neuron index |
| emu_start | output | 1 | Emulation start pulse |
| dev_spk_valid | input | 1 | Output spike from the device |
| dev_spk_idx | input | 8 | Output spike neuron index |
| rd_valid | output | 1 | Record available for readback |
| rd_data | output | 24 | Oldest record |
| rd_ready | input | 1 | Host takes the record |
| rd_done | output | 1 | Draining phase with empty buffer |
| overflow | output | 1 | Sticky lost-event flag |

## Verification
Some internal faults show up within one cycle:
- A wrong program counter or a mis-decoded opcode gives a configuration, spike or start pulse on the wrong cycle or with the wrong fields.
- A timestamp counter that fails to restart or to advance moves a spike release away from its expected cycle.

Other faults stay hidden until readback:
- A wrong buffer pointer or count appears only when the records drain, as data out of order, a missing or extra `rd_valid`, or `rd_done` at the wrong time.
- A timestamp fault also leaves wrong low 16 bits in the recorded words.

Overflow faults show on the `overflow` flag as soon as the ninth event of a run arrives.

// File: rtl/spike_playback_pkg.sv
package spike_playback_pkg;

    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,
        PH_RUN  = 2'd1,
        PH_READ = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        OP_CFG   = 2'b00,
        OP_SPIKE = 2'b01,
        OP_START = 2'b10,
        OP_END   = 2'b11
    } opcode_e;

    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 14;
    localparam int DATA_W  = 16;
    localparam int IDX_W   = 8;
    localparam int TS_W    = 16;
    localparam int REC_W   = IDX_W + TS_W;

endpackage

// File: rtl/cmd_store.sv
module cmd_store #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clr)
            count_d = '0;
        else if (wr_en && !full)
            count_d = count_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full && !clr)
            mem[count_q[AW-1:0]] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
    assign count   = count_q;
    assign full    = (count_q == CW'(DEPTH));
endmodule

// File: rtl/rec_fifo.sv
module rec_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 24,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t     d, q;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (push) d.wp = bump(q.wp);
            if (pop)  d.rp = bump(q.rp);
            if (push && !pop)      d.cnt = q.cnt + CW'(1);
            else if (pop && !push) d.cnt = q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr)
            mem[q.wp] <= push_data;
    end

    assign head  = mem[q.rp];
    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
endmodule

// File: rtl/spike_playback_top.sv
module spike_playback_top
    import spike_playback_pkg::*;
#(
    parameter int CMD_DEPTH = 16,
    parameter int REC_DEPTH = 8,
    parameter int TO_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [31:0]       cmd_data,
    output logic              cmd_ready,
    input  logic              run_go,
    input  logic [TO_W-1:0]   run_timeout,
    output logic              busy,
    output logic              cfg_valid,
    output logic [13:0]       cfg_addr,
    output logic [15:0]       cfg_data,
    output logic              stim_valid,
    output logic [7:0]        stim_idx,
    output logic              emu_start,
    input  logic              dev_spk_valid,
    input  logic [7:0]        dev_spk_idx,
    output logic              rd_valid,
    output logic [23:0]       rd_data,
    input  logic              rd_ready,
    output logic              rd_done,
    output logic              overflow
);
    localparam int AW = $clog2(CMD_DEPTH);
    localparam int CW = $clog2(CMD_DEPTH + 1);

    typedef struct packed {
        phase_e              phase;
        logic [CW-1:0]       pc;
        logic [TS_W-1:0]     ts;
        logic [TO_W-1:0]     run_cnt;
        logic                ovf;
        logic                cfg_valid;
        logic [ADDR_W-1:0]   cfg_addr;
        logic [DATA_W-1:0]   cfg_data;
        logic                stim_valid;
        logic [IDX_W-1:0]    stim_idx;
        logic                emu_start;
    } st_t;

    st_t d, q;

    logic [WORD_W-1:0] cur_cmd;
    logic [CW-1:0]     store_count;
    logic              store_full, store_wr, store_clr;
    logic              fifo_push, fifo_pop, fifo_clr, fifo_empty, fifo_full;
    logic [REC_W-1:0]  fifo_head;
    opcode_e           op;

    cmd_store #(.DEPTH(CMD_DEPTH), .W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (store_clr),
        .wr_en   (store_wr),
        .wr_data (cmd_data),
        .rd_addr (q.pc[AW-1:0]),
        .rd_data (cur_cmd),
        .count   (store_count),
        .full    (store_full)
    );

    rec_fifo #(.DEPTH(REC_DEPTH), .W(REC_W)) u_rec (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fifo_clr),
        .push      (fifo_push),
        .push_data ({dev_spk_idx, q.ts}),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    assign op = opcode_e'(cur_cmd[31:30]);

    always_comb begin
        d            = q;
        d.cfg_valid  = 1'b0;
        d.stim_valid = 1'b0;
        d.emu_start  = 1'b0;
        store_wr     = 1'b0;
        store_clr    = 1'b0;
        fifo_push    = 1'b0;
        fifo_pop     = 1'b0;
        fifo_clr     = 1'b0;
        case (q.phase)
            PH_LOAD: begin
                store_wr = cmd_valid && !store_full;
                if (run_go) begin
                    d.phase   = PH_RUN;
                    d.pc      = '0;
                    d.ts      = '0;
                    d.run_cnt = '0;
                end
            end
            PH_RUN: begin
                d.ts      = q.ts + TS_W'(1);
                d.run_cnt = q.run_cnt + TO_W'(1);
                if (dev_spk_valid) begin
                    if (fifo_full) d.ovf = 1'b1;
                    else           fifo_push = 1'b1;
                end
                if (run_timeout != '0 && q.run_cnt == run_timeout) begin
                    d.phase = PH_READ;
                end else if (q.pc == store_count) begin
                    d.phase = PH_READ;
                end else begin
                    case (op)
                        OP_CFG: begin
                            d.cfg_valid = 1'b1;
                            d.cfg_addr  = cur_cmd[29:16];
                            d.cfg_data  = cur_cmd[15:0];
                            d.pc        = q.pc + CW'(1);
                        end
                        OP_SPIKE: begin
                            if (q.ts >= cur_cmd[15:0]) begin
                                d.stim_valid = 1'b1;
                                d.stim_idx   = cur_cmd[23:16];
                                d.pc         = q.pc + CW'(1);
                            end
                        end
                        OP_START: begin
                            d.emu_start = 1'b1;
                            d.ts        = '0;
                            d.pc        = q.pc + CW'(1);
                        end
                        OP_END: d.phase = PH_READ;
                        default: d.phase = PH_READ;
                    endcase
                end
            end
            PH_READ: begin
                fifo_pop = rd_ready && !fifo_empty;
                if (run_go) begin
                    d.phase   = PH_LOAD;
                    d.ovf     = 1'b0;
                    store_clr = 1'b1;
                    fifo_clr  = 1'b1;
                end
            end
            default: d.phase = PH_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_LOAD;
        end else begin
            q <= d;
        end
    end

    assign cmd_ready  = (q.phase == PH_LOAD) && !store_full;
    assign busy       = (q.phase == PH_RUN);
    assign cfg_valid  = q.cfg_valid;
    assign cfg_addr   = q.cfg_addr;
    assign cfg_data   = q.cfg_data;
    assign stim_valid = q.stim_valid;
    assign stim_idx   = q.stim_idx;
    assign emu_start  = q.emu_start;
    assign rd_valid   = (q.phase == PH_READ) && !fifo_empty;
    assign rd_data    = fifo_head;
    assign rd_done    = (q.phase == PH_READ) && fifo_empty;
    assign overflow   = q.ovf;
endmodule

// File: rtl/spike_playback_checks.sv
module spike_playback_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_ready,
    input logic        run_go,
    input logic        busy,
    input logic        cfg_valid,
    input logic        stim_valid,
    input logic        emu_start,
    input logic        rd_valid,
    input logic [23:0] rd_data,
    input logic        rd_ready,
    input logic        rd_done,
    input logic        overflow
);
    logic in_read;
    assign in_read = rd_valid || rd_done;

    AST_LOAD_NOT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !busy); // R1

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_valid, stim_valid, emu_start})); // R2

    AST_CFG_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> $past(busy)); // R2

    AST_STIM_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        stim_valid |-> $past(busy)); // R3

    AST_START_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        emu_start |-> $past(busy)); // R4

    AST_RUN_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_read); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !(in_read && run_go) |=> overflow); // R7

    AST_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rd_done)); // R8

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready && !run_go |=> rd_valid && $stable(rd_data)); // R8

    AST_CLEAR_TO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        in_read && run_go |=> cmd_ready && !overflow); // R9
endmodule

bind spike_playback_top spike_playback_checks u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_ready  (cmd_ready),
    .run_go     (run_go),
    .busy       (busy),
    .cfg_valid  (cfg_valid),
    .stim_valid (stim_valid),
    .emu_start  (emu_start),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .rd_ready   (rd_ready),
    .rd_done    (rd_done),
    .overflow   (overflow)
);

// File: tb/spike_playback_top_tb.sv
module spike_playback_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CMD_DEPTH  = 16;
    localparam int REC_DEPTH  = 8;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_data = '0;
    logic        cmd_ready;
    logic        run_go = 1'b0;
    logic [15:0] run_timeout = '0;
    logic        busy;
    logic        cfg_valid;
    logic [13:0] cfg_addr;
    logic [15:0] cfg_data;
    logic        stim_valid;
    logic [7:0]  stim_idx;
    logic        emu_start;
    logic        dev_spk_valid = 1'b0;
    logic [7:0]  dev_spk_idx = '0;
    logic        rd_valid;
    logic [23:0] rd_data;
    logic        rd_ready = 1'b0;
    logic        rd_done;
    logic        overflow;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spike_playback_top #(.CMD_DEPTH(CMD_DEPTH), .REC_DEPTH(REC_DEPTH), .TO_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .run_go(run_go), .run_timeout(run_timeout), .busy(busy),
        .cfg_valid(cfg_valid), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .stim_valid(stim_valid), .stim_idx(stim_idx), .emu_start(emu_start),
        .dev_spk_valid(dev_spk_valid), .dev_spk_idx(dev_spk_idx),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
        .rd_done(rd_done), .overflow(overflow)
    );

    // Behavioural reference: 0 = loading, 1 = running, 2 = draining
    int          m_phase;
    logic [31:0] m_cmds [$];
    logic [23:0] m_rec  [$];
    int          m_pc;
    logic [15:0] m_ts, m_cnt;
    bit          m_ovf, m_cfg_v, m_stim_v, m_start;
    logic [13:0] m_cfg_a;
    logic [15:0] m_cfg_d;
    logic [7:0]  m_stim_i;

    always @(posedge clk) begin : ref_model
        logic [31:0] c;
        logic [15:0] old_ts, old_cnt;
        cycles++;
        if (!rst_n) begin
            m_phase = 0; m_cmds.delete(); m_rec.delete();
            m_pc = 0; m_ts = 0; m_cnt = 0; m_ovf = 0;
            m_cfg_v = 0; m_stim_v = 0; m_start = 0;
            m_cfg_a = 0; m_cfg_d = 0; m_stim_i = 0;
        end else begin
            m_cfg_v = 0; m_stim_v = 0; m_start = 0;
            case (m_phase)
                0: begin
                    if (cmd_valid && m_cmds.size() < CMD_DEPTH) m_cmds.push_back(cmd_data);
                    if (run_go) begin m_phase = 1; m_pc = 0; m_ts = 0; m_cnt = 0; end
                end
                1: begin
                    if (dev_spk_valid) begin
                        if (m_rec.size() == REC_DEPTH) m_ovf = 1;
                        else m_rec.push_back({dev_spk_idx, m_ts});
                    end
                    old_ts = m_ts; old_cnt = m_cnt;
                    m_ts = m_ts + 1; m_cnt = m_cnt + 1;
                    if (run_timeout != 0 && old_cnt == run_timeout) m_phase = 2;
                    else if (m_pc == m_cmds.size()) m_phase = 2;
                    else begin
                        c = m_cmds[m_pc];
                        case (c[31:30])
                            2'b00: begin m_cfg_v = 1; m_cfg_a = c[29:16]; m_cfg_d = c[15:0]; m_pc++; end
                            2'b01: if (old_ts >= c[15:0]) begin m_stim_v = 1; m_stim_i = c[23:16]; m_pc++; end
                            2'b10: begin m_start = 1; m_ts = 0; m_pc++; end
                            default: m_phase = 2;
                        endcase
                    end
                end
                default: begin
                    if (rd_ready && m_rec.size() > 0) void'(m_rec.pop_front());
                    if (run_go) begin m_phase = 0; m_cmds.delete(); m_rec.delete(); m_ovf = 0; end
                end
            endcase
        end
    end

    task automatic chk(input string req, input string name, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, name, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        string rq;
        rq = rst_n ? "" : "R10 ";
        chk({rq, "R1"}, "cmd_ready", 32'(cmd_ready), 32'(m_phase == 0 && m_cmds.size() < CMD_DEPTH));
        chk({rq, "R5"}, "busy", 32'(busy), 32'(m_phase == 1));
        chk({rq, "R2"}, "cfg_valid", 32'(cfg_valid), 32'(m_cfg_v));
        if (m_cfg_v) begin
            chk("R2", "cfg_addr", 32'(cfg_addr), 32'(m_cfg_a));
            chk("R2", "cfg_data", 32'(cfg_data), 32'(m_cfg_d));
        end
        chk({rq, "R3"}, "stim_valid", 32'(stim_valid), 32'(m_stim_v));
        if (m_stim_v) chk("R3", "stim_idx", 32'(stim_idx), 32'(m_stim_i));
        chk({rq, "R4"}, "emu_start", 32'(emu_start), 32'(m_start));
        chk({rq, "R8"}, "rd_valid", 32'(rd_valid), 32'(m_phase == 2 && m_rec.size() > 0));
        chk({rq, "R8"}, "rd_done", 32'(rd_done), 32'(m_phase == 2 && m_rec.size() == 0));
        // recorded timestamps also expose the restart of R4
        if (m_phase == 2 && m_rec.size() > 0) chk("R6/R4", "rd_data", 32'(rd_data), 32'(m_rec[0]));
        chk({rq, "R7"}, "overflow", 32'(overflow), 32'(m_ovf));
    end

    task automatic put(input logic [31:0] w);
        cmd_valid = 1'b1; cmd_data = w;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_go();
        run_go = 1'b1;
        @(negedge clk);
        run_go = 1'b0;
    endtask

    task automatic play(input int every);
        for (int k = 0; k < 500 && busy; k++) begin
            dev_spk_valid = ((k % every) == 0);
            dev_spk_idx   = 8'(k + 16);
            @(negedge clk);
        end
        dev_spk_valid = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 200 && !rd_done; k++) begin
            rd_ready = ((k % 3) != 1);
            @(negedge clk);
        end
        rd_ready = 1'b0;
    endtask

    task automatic back_to_load();
        pulse_go();
        chk("R9", "cmd_ready after clear", 32'(cmd_ready), 32'd1);
        chk("R9", "overflow after clear", 32'(overflow), 32'd0);
        chk("R9", "rd_valid after clear", 32'(rd_valid), 32'd0);
    endtask

    initial begin : watchdog
        wait (cycles > WATCHDOG);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Mixed list: config, start, delayed spike, config, overdue spike, end
        put(32'h0005_BEEF);
        put(32'h8000_0000);
        put(32'h4003_0006);
        put(32'h0001_0002);
        put(32'h4007_0002);
        put(32'hC000_0000);
        pulse_go();
        play(3);
        drain();
        back_to_load();

        // Overflow: long wait on a spike while the device fires every cycle (R7)
        put(32'h8000_0000);
        put(32'h4001_0014);
        put(32'hC000_0000);
        pulse_go();
        play(1);
        chk("R7", "overflow set", 32'(overflow), 32'd1);
        drain();
        back_to_load();

        // Timeout ends a run stuck on a far spike (R5)
        run_timeout = 16'd5;
        put(32'h4009_03E8);
        put(32'hC000_0000);
        pulse_go();
        play(4);
        chk("R5", "busy after timeout", 32'(busy), 32'd0);
        drain();
        back_to_load();
        run_timeout = 16'd0;

        // Full list with no end word: extra word dropped, list runs out (R1, R5)
        for (int k = 0; k < CMD_DEPTH; k++) put(32'((k << 16) | (k * 3)));
        chk("R1", "cmd_ready when full", 32'(cmd_ready), 32'd0);
        put(32'h4002_0000);
        pulse_go();
        play(2);
        drain();
        back_to_load();

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule